// File: doc/BRIEF.md
# GPU Interrupt Status and Mask Registers

This block collects three interrupt sources from a graphics engine and raises one interrupt line to the host. The sources are the end of a binning flush, the end of a rendered frame, and the binner running out of memory. The first two are one-shot pulses. Each pulse latches a status bit, and software acknowledges it by writing a 1 to that bit.

The out-of-memory source works differently. It is a level condition, and it holds while the overflow pool size register is zero. The status bit latches again on every cycle the condition lasts, so clearing it has no lasting effect until software supplies memory. Software does that by programming a pool base address and a non-zero pool size, then clearing the status bit.

The enable mask is written through two registers. One sets mask bits and the other clears them, and a 0 written to either one changes nothing. Both registers read back the current mask. The engine reports that it has used up the pool with a drain pulse, which zeroes the pool size.

Top module: `gpu_irq_regs`

## Requirements
- R1: While rst_ni is low, the status bits, mask, pool address, pool size, rdata_o and irq_o are all zero.
- R2: A write to the status register (word 0) with a 1 in a bit clears that bit on the next edge. A 0 in a bit leaves that bit unchanged.
- R3: Writing 1s to the set register (word 1) enables those mask bits. Writing 1s to the clear register (word 2) disables them. A 0 in either register leaves the mask unchanged, and reading either register returns the mask.
- R4: A frame-done pulse sets status bit 0 and a flush-done pulse sets status bit 1. Once cleared, a bit stays clear until a new pulse arrives.
- R5: If a pulse arrives in the same cycle as a write-1 clear of its own bit, the bit ends up set.
- R6: On every edge where the pool size register is zero, status bit 2 (out of memory) is set, including right after a clear.
- R7: Writing to the pool size register (word 4) loads it. A drain pulse zeroes it. If a write and a drain happen in the same cycle, the write wins.
- R8: irq_o is high exactly when some status bit and the same mask bit are both set.
- R9: Status and mask bits 31 down to 3 read as zero and ignore writes. Addresses 5 to 7 read as zero and have no effect when written.
- R10: rdata_o shows the register selected by addr_i one cycle later, with the value the register held before that edge.
- R11: The pool address register (word 3) is a full 32-bit register, loaded by a write and driven on pool_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| frame_done_i | input | 1 | Render frame done pulse |
| flush_done_i | input | 1 | Binner flush done pulse |
| pool_drain_i | input | 1 | Engine has used up the overflow pool |
| pool_addr_o | output | 32 | Overflow pool base address |
| pool_size_o | output | 32 | Overflow pool size, in bytes remaining |
| irq_o | output | 1 | Interrupt to host |

## Verification
Each register reacts on the first rising edge after its write or pulse. irq_o and the pool outputs follow that edge with no extra delay. Read data arrives one edge after the address is presented.

The bench drives stimulus on falling edges. A behavioural model advances on the same rising edge as the design, and every output is compared with the model at the next falling edge, so each result is checked in the cycle it is due. Directed reads sample rdata_o one full cycle after the address, as R10 specifies. The out-of-memory bit is also checked after a clear and after a drain, to confirm it latches again on the edge that follows.

// File: rtl/gpu_irq_pkg.sv
package gpu_irq_pkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_FRAME = 0;
  localparam int SRC_FLUSH = 1;
  localparam int SRC_OOM   = 2;

  localparam int unsigned REG_STAT      = 0;
  localparam int unsigned REG_EN_SET    = 1;
  localparam int unsigned REG_EN_CLR    = 2;
  localparam int unsigned REG_POOL_ADDR = 3;
  localparam int unsigned REG_POOL_SIZE = 4;
endpackage

// File: rtl/gpu_irq_status.sv
module gpu_irq_status #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // event beats acknowledge so no edge is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q[i] <= 1'b0;
      else if (evt_i[i])  q[i] <= 1'b1;
      else if (clr_i[i])  q[i] <= 1'b0;
    end
  end

  assign stat_o = q;
endmodule

// File: rtl/gpu_irq_mask.sv
module gpu_irq_mask #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/gpu_irq_pool.sv
module gpu_irq_pool #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic              size_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              drain_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] size_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] addr_q, size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (addr_we_i) addr_q <= wdata_i;
  end

  // fresh pool from software outranks the engine's drain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        size_q <= '0;
    else if (size_we_i) size_q <= wdata_i;
    else if (drain_i)   size_q <= '0;
  end

  assign addr_o  = addr_q;
  assign size_o  = size_q;
  assign empty_o = (size_q == '0);
endmodule

// File: rtl/gpu_irq_regs.sv
module gpu_irq_regs
  import gpu_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_done_i,
  input  logic              flush_done_i,
  input  logic              pool_drain_i,
  output logic [DATA_W-1:0] pool_addr_o,
  output logic [DATA_W-1:0] pool_size_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic              wr_stat, wr_set, wr_clr, wr_paddr, wr_psize;
  logic [NUM_SRC-1:0] evt, stat_q, en_q, wsrc;
  logic              pool_empty;
  logic [DATA_W-1:0] paddr_q, psize_q, rdata_d, rdata_q;

  assign wsrc     = wdata_i[NUM_SRC-1:0];
  assign wr_stat  = wr_en_i && (addr_i == ADDR_W'(REG_STAT));
  assign wr_set   = wr_en_i && (addr_i == ADDR_W'(REG_EN_SET));
  assign wr_clr   = wr_en_i && (addr_i == ADDR_W'(REG_EN_CLR));
  assign wr_paddr = wr_en_i && (addr_i == ADDR_W'(REG_POOL_ADDR));
  assign wr_psize = wr_en_i && (addr_i == ADDR_W'(REG_POOL_SIZE));

  always_comb begin
    evt            = '0;
    evt[SRC_FRAME] = frame_done_i;
    evt[SRC_FLUSH] = flush_done_i;
    evt[SRC_OOM]   = pool_empty;
  end

  gpu_irq_status #(.N(NUM_SRC)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (wr_stat ? wsrc : '0),
    .stat_o (stat_q)
  );

  gpu_irq_mask #(.N(NUM_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_set ? wsrc : '0),
    .clr_i  (wr_clr ? wsrc : '0),
    .en_o   (en_q)
  );

  gpu_irq_pool #(.DATA_W(DATA_W)) u_pool (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_we_i (wr_paddr),
    .size_we_i (wr_psize),
    .wdata_i   (wdata_i),
    .drain_i   (pool_drain_i),
    .addr_o    (paddr_q),
    .size_o    (psize_q),
    .empty_o   (pool_empty)
  );

  always_comb begin
    rdata_d = '0;
    if (addr_i == ADDR_W'(REG_STAT))
      rdata_d = {{PAD_W{1'b0}}, stat_q};
    else if (addr_i == ADDR_W'(REG_EN_SET) || addr_i == ADDR_W'(REG_EN_CLR))
      rdata_d = {{PAD_W{1'b0}}, en_q};
    else if (addr_i == ADDR_W'(REG_POOL_ADDR))
      rdata_d = paddr_q;
    else if (addr_i == ADDR_W'(REG_POOL_SIZE))
      rdata_d = psize_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o     = rdata_q;
  assign pool_addr_o = paddr_q;
  assign pool_size_o = psize_q;
  assign irq_o       = |(stat_q & en_q);
endmodule

// File: rtl/gpu_irq_regs_chk.sv
module gpu_irq_regs_chk
  import gpu_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               frame_done_i,
  input logic               flush_done_i,
  input logic               pool_drain_i,
  input logic [DATA_W-1:0]  pool_size_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q
);
  logic size_wr, mask_wr;
  assign size_wr = wr_en_i && (addr_i == ADDR_W'(REG_POOL_SIZE));
  assign mask_wr = wr_en_i && (addr_i == ADDR_W'(REG_EN_SET) || addr_i == ADDR_W'(REG_EN_CLR));

  a_r6_oom_relatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pool_size_o == '0) |=> stat_q[SRC_OOM]);

  a_r5_frame_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> stat_q[SRC_FRAME]);

  a_r5_flush_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_i |=> stat_q[SRC_FLUSH]);

  a_r4_frame_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_q[SRC_FRAME] && !frame_done_i) |=> !stat_q[SRC_FRAME]);

  a_r3_mask_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(en_q));

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_wr |=> (pool_size_o == $past(wdata_i)));

  a_r7_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pool_drain_i && !size_wr) |=> (pool_size_o == '0));

  a_r8_oom_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[SRC_OOM] && en_q[SRC_OOM]) |-> irq_o);

  a_r8_no_mask_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(REG_STAT)) |=> (rdata_o[DATA_W-1:NUM_SRC] == '0));
endmodule

bind gpu_irq_regs gpu_irq_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .frame_done_i (frame_done_i),
  .flush_done_i (flush_done_i),
  .pool_drain_i (pool_drain_i),
  .pool_size_o  (pool_size_o),
  .irq_o        (irq_o),
  .stat_q       (stat_q),
  .en_q         (en_q)
);

// File: tb/sim_gpu_irq_regs.sv
`timescale 1ns/1ps
module sim_gpu_irq_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        frame_done_i = 1'b0, flush_done_i = 1'b0, pool_drain_i = 1'b0;
  logic [31:0] rdata_o, pool_addr_o, pool_size_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  gpu_irq_regs u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .frame_done_i(frame_done_i),
    .flush_done_i(flush_done_i), .pool_drain_i(pool_drain_i),
    .pool_addr_o(pool_addr_o), .pool_size_o(pool_size_o), .irq_o(irq_o)
  );

  // behavioural reference
  bit [31:0] m_stat, m_en, m_paddr, m_psize, m_rdata;

  always @(posedge clk_i or negedge rst_ni) begin
    bit [31:0] ns, ne, np, nz, nr;
    if (!rst_ni) begin
      m_stat = 0; m_en = 0; m_paddr = 0; m_psize = 0; m_rdata = 0;
    end else begin
      case (addr_i)
        3'd0:       nr = m_stat;
        3'd1, 3'd2: nr = m_en;
        3'd3:       nr = m_paddr;
        3'd4:       nr = m_psize;
        default:    nr = 0;
      endcase
      ns = m_stat; ne = m_en; np = m_paddr; nz = m_psize;
      if (wr_en_i && addr_i == 0) ns = ns & ~wdata_i;
      if (frame_done_i) ns[0] = 1;
      if (flush_done_i) ns[1] = 1;
      if (m_psize == 0) ns[2] = 1;
      ns = ns & 32'h7;
      if (wr_en_i && addr_i == 1) ne = (ne | wdata_i) & 32'h7;
      if (wr_en_i && addr_i == 2) ne = ne & ~wdata_i;
      if (wr_en_i && addr_i == 3) np = wdata_i;
      if (wr_en_i && addr_i == 4) nz = wdata_i;
      else if (pool_drain_i)      nz = 0;
      m_stat = ns; m_en = ne; m_paddr = np; m_psize = nz; m_rdata = nr;
    end
  end

  task automatic chk(input bit [31:0] act, input bit [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !done) begin
    chk({31'd0, irq_o}, {31'd0, (m_stat & m_en) != 0}, "R8 irq");
    chk(rdata_o, m_rdata, "R10 rdata");
    chk(pool_size_o, m_psize, "R7 pool size");
    chk(pool_addr_o, m_paddr, "R11 pool addr");
  end

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0; wdata_i = 0;
  endtask

  task automatic rd(input bit [2:0] a, input bit [31:0] exp, input string req);
    @(negedge clk_i); wr_en_i = 0; addr_i = a;
    @(negedge clk_i); chk(rdata_o, exp, req);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    repeat (4) @(negedge clk_i);
    // R1 reset state
    chk({31'd0, irq_o}, 0, "R1 irq");
    chk(rdata_o, 0, "R1 rdata");
    chk(pool_size_o, 0, "R1 size");
    chk(pool_addr_o, 0, "R1 addr");
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    // R6 empty pool latches out-of-memory, and it re-latches after a clear
    rd(0, 32'h4, "R6 oom set");
    wr(0, 32'h4);
    rd(0, 32'h4, "R6 oom relatch");
    // R11 / R7 supply memory then acknowledge
    wr(3, 32'hCAFE_1000);
    rd(3, 32'hCAFE_1000, "R11 pool addr");
    wr(4, 32'h0000_0100);
    rd(4, 32'h0000_0100, "R7 pool size");
    wr(0, 32'h4);
    rd(0, 32'h0, "R6 oom cleared");
    // R3 mask set / clear, zeros ignored
    wr(1, 32'hFFFF_FFFF);
    rd(2, 32'h7, "R3 R9 mask via clear reg");
    wr(2, 32'h2);
    rd(1, 32'h5, "R3 mask after clear");
    wr(1, 32'h0);
    wr(2, 32'h0);
    rd(1, 32'h5, "R3 zero write ignored");
    // R4 frame event, acknowledge, stays clear
    @(negedge clk_i); frame_done_i = 1;
    @(negedge clk_i); frame_done_i = 0;
    chk({31'd0, irq_o}, 1, "R8 irq on frame");
    rd(0, 32'h1, "R4 frame set");
    wr(0, 32'h0);
    rd(0, 32'h1, "R2 zero write keeps");
    wr(0, 32'h1);
    repeat (3) @(negedge clk_i);
    rd(0, 32'h0, "R4 frame stays clear");
    chk({31'd0, irq_o}, 0, "R8 irq low");
    // R8 masked flush event does not raise irq
    @(negedge clk_i); flush_done_i = 1;
    @(negedge clk_i); flush_done_i = 0;
    chk({31'd0, irq_o}, 0, "R8 masked flush");
    rd(0, 32'h2, "R4 flush set");
    // R5 event together with clear
    @(negedge clk_i); frame_done_i = 1; wr_en_i = 1; addr_i = 0; wdata_i = 32'h3;
    @(negedge clk_i); frame_done_i = 0; wr_en_i = 0; wdata_i = 0;
    rd(0, 32'h1, "R5 event wins");
    wr(0, 32'h1);
    // R7 drain then write-wins
    @(negedge clk_i); pool_drain_i = 1;
    @(negedge clk_i); pool_drain_i = 0;
    chk(pool_size_o, 0, "R7 drained");
    @(negedge clk_i);
    chk({31'd0, irq_o}, 1, "R6 oom after drain");
    @(negedge clk_i); pool_drain_i = 1; wr_en_i = 1; addr_i = 4; wdata_i = 32'h40;
    @(negedge clk_i); pool_drain_i = 0; wr_en_i = 0; wdata_i = 0;
    chk(pool_size_o, 32'h40, "R7 write beats drain");
    wr(0, 32'h4);
    rd(0, 32'h0, "R7 condition removed");
    // R9 unused address
    wr(5, 32'hFFFF_FFFF);
    rd(5, 32'h0, "R9 unused addr");
    rd(0, 32'h0, "R9 status untouched");
    rd(1, 32'h5, "R9 mask untouched");
    repeat (2) @(negedge clk_i);
    done = 1;
    summary();
  end
endmodule